// File: doc/BRIEF.md
# Serial Volume Command Attenuator

This block receives volume settings from a host microcontroller over a slow three-wire link made of a data line, a shift clock and a load strobe. It applies the selected gain to a stream of 16-bit signed stereo sample pairs. The three host lines are resynchronised to the block clock. Bits are shifted in on rising edges of the host clock. A falling edge on the load line commits the command, but only when its 8-bit key matches.

The committed 6-bit level code picks an entry from a 64-step, non-uniform gain table. The table holds unsigned Q1.15 fractions, and its last code silences the output. Each sample pair that arrives is captured together with the gain in force at that moment. Both channels are then multiplied by that gain, rounded to nearest, saturated to 16 bits and presented two clock cycles later.

Top module: `vol_cmd_atten`

## Requirements
- R1: A command is 14 bits sent least significant bit first. Bits are taken on rising edges of `host_clk` while `host_load` is high, so the i-th bit sent becomes command bit i. Command bits [7:0] form the key and bits [13:8] form the level code.
- R2: A falling edge of `host_load` commits the level code when the key equals 0x5D.
- R3: When the key is not 0x5D at a falling edge of `host_load`, the command is dropped and the previous level stays in force.
- R4: While `rst_n` is low, `out_valid`, `out_left` and `out_right` are zero and incoming samples are not processed. After reset the level code is 0.
- R5: The gain table is unsigned Q1.15 (32768 = 1.0) and includes the following entries: code 0 = 32768 (0 dB), code 1 = 31729 (-0.28 dB), code 31 = 16385 (-6.02 dB), code 32 = 15865 (-6.30 dB), code 62 = 512 (-36.12 dB).
- R6: Level code 63 mutes the output: both output channels are 0 for every sample pair.
- R7: Each output equals floor((sample * gain + 16384) / 32768), clamped to the range -32768 to 32767.
- R8: A pair presented with `smp_valid` on one rising edge appears with `out_valid` high after the second rising edge that follows it.
- R9: A committed level applies from the next sample pair onward, and both channels of a pair are always scaled by the same gain.
- R10: Rising edges of `host_clk` while `host_load` is low do not shift the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 1 | Serial command data from the host |
| host_clk | input | 1 | Host shift clock, idles high |
| host_load | input | 1 | Host load strobe, active low |
| smp_valid | input | 1 | A stereo sample pair is present |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| out_valid | output | 1 | Scaled pair is present |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |

## Verification
The bench aims at the command path's traps. It sends a key that differs in a single bit, which a design with a loose key compare would accept. It clocks a second command while the load line is still low and then loads again; a design that shifts during load would pick up the second code. It also checks the bit order, which a design shifting the wrong way would scramble into a rejected key.

On the datapath it drives full-scale positive and negative samples, odd values near zero and half-way rounding cases at the table's anchor gains. A truncating or sign-mishandling multiplier would be off by one on the negative inputs. Other checks cover muting at the top code, the fixed two-cycle latency, and a level change landing between pairs with different left and right values.

// File: rtl/vca_pkg.sv
package vca_pkg;

  localparam int SMP_W     = 16;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 15;
  localparam int CMD_W     = 14;
  localparam int KEY_W     = 8;
  localparam logic [KEY_W-1:0] CMD_KEY = 8'h5D;

  // Q1.15 gains for each level code; codes beyond 62 give silence
  function automatic logic [GAIN_W-1:0] gain_lut(input int code);
    logic [GAIN_W-1:0] g;
    case (code)
      0:  g = 16'd32768;  1:  g = 16'd31729;  2:  g = 16'd31221;  3:  g = 16'd30722;
      4:  g = 16'd30196;  5:  g = 16'd29679;  6:  g = 16'd29171;  7:  g = 16'd28672;
      8:  g = 16'd28149;  9:  g = 16'd27635;  10: g = 16'd27130;  11: g = 16'd26635;
      12: g = 16'd26119;  13: g = 16'd25613;  14: g = 16'd25087;  15: g = 16'd24573;
      16: g = 16'd24069;  17: g = 16'd23548;  18: g = 16'd23039;  19: g = 16'd22540;
      20: g = 16'd22027;  21: g = 16'd21501;  22: g = 16'd20987;  23: g = 16'd20486;
      24: g = 16'd19974;  25: g = 16'd19452;  26: g = 16'd18943;  27: g = 16'd18427;
      28: g = 16'd17925;  29: g = 16'd17416;  30: g = 16'd16903;  31: g = 16'd16385;
      32: g = 16'd15865;  33: g = 16'd15362;  34: g = 16'd14841;  35: g = 16'd14337;
      36: g = 16'd13818;  37: g = 16'd13318;  38: g = 16'd12807;  39: g = 16'd12287;
      40: g = 16'd11775;  41: g = 16'd11258;  42: g = 16'd10751;  43: g = 16'd10244;
      44: g = 16'd9726;   45: g = 16'd9214;   46: g = 16'd8709;   47: g = 16'd8193;
      48: g = 16'd7682;   49: g = 16'd7169;   50: g = 16'd6660;   51: g = 16'd6144;
      52: g = 16'd5629;   53: g = 16'd5122;   54: g = 16'd4607;   55: g = 16'd4097;
      56: g = 16'd3585;   57: g = 16'd3072;   58: g = 16'd2561;   59: g = 16'd2049;
      60: g = 16'd1536;   61: g = 16'd1024;   62: g = 16'd512;
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/vca_sync.sv
module vca_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] nxt;
    logic [N-1:0] q;
    if (s == 0) begin : g_first
      assign nxt = din;
    end else begin : g_next
      assign nxt = g_stage[s-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
    end
  end

  assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/vca_cmd_rx.sv
module vca_cmd_rx #(
  parameter int CMD_W = 14,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'h5D,
  localparam int CODE_W = CMD_W - KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdat,
  input  logic              sclk,
  input  logic              sload,
  output logic [CODE_W-1:0] level
);

  logic              sclk_q, sload_q;
  logic [CMD_W-1:0]  sr_q, sr_d;
  logic [CODE_W-1:0] level_q, level_d;
  logic              sclk_rise, load_fall, key_ok, shift_en;

  always_comb begin
    sclk_rise = sclk & ~sclk_q;
    load_fall = ~sload & sload_q;
    shift_en  = sclk_rise & sload;
    key_ok    = (sr_q[KEY_W-1:0] == KEY);
    sr_d      = sr_q;
    level_d   = level_q;
    if (shift_en) sr_d = {sdat, sr_q[CMD_W-1:1]};
    if (load_fall && key_ok) level_d = sr_q[CMD_W-1:KEY_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b1;
      sload_q <= 1'b1;
      sr_q    <= '0;
      level_q <= '0;
    end else begin
      sclk_q  <= sclk;
      sload_q <= sload;
      if (shift_en) sr_q <= sr_d;
      if (load_fall) level_q <= level_d;
    end
  end

  assign level = level_q;

  // R2: a matching key commits the shifted code
  a_r2_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall && key_ok) |=> (level_q == $past(sr_q[CMD_W-1:KEY_W])));
  // R3: a wrong key leaves the level alone
  a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall && !key_ok) |=> $stable(level_q));
  // R10: no shifting while the strobe is low
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sload |=> $stable(sr_q));

endmodule

// File: rtl/vca_gain_rom.sv
module vca_gain_rom #(
  parameter int CODE_W = 6,
  parameter int GAIN_W = vca_pkg::GAIN_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [GAIN_W-1:0] gain
);

  always_comb gain = GAIN_W'(vca_pkg::gain_lut(int'(code)));

endmodule

// File: rtl/vca_scale.sv
module vca_scale #(
  parameter int SMP_W = 16,
  parameter int GAIN_W = 16,
  parameter int FRAC = 15,
  localparam int PW = SMP_W + GAIN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [SMP_W-1:0] smp,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [SMP_W-1:0] y
);

  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) << (SMP_W - 1));

  logic signed [PW-1:0]    prod, rnd, shf;
  logic signed [SMP_W-1:0] y_d, y_q;

  always_comb begin
    prod = PW'(smp) * $signed({1'b0, gain});
    rnd  = prod + HALF;
    shf  = rnd >>> FRAC;
    if (shf > MAXV)      y_d = MAXV[SMP_W-1:0];
    else if (shf < MINV) y_d = MINV[SMP_W-1:0];
    else                 y_d = shf[SMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  y_q <= '0;
    else if (en) y_q <= y_d;
  end

  assign y = y_q;

  function automatic logic [SMP_W:0] mag(input logic signed [SMP_W-1:0] v);
    logic signed [SMP_W:0] w;
    w = SMP_W'(v) == v ? (SMP_W+1)'(v) : '0;
    return (w < 0) ? -w : w;
  endfunction

  // R7: a gain of at most 1.0 never grows the magnitude
  a_r7_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (mag(y_q) <= mag($past(smp))));

endmodule

// File: rtl/vol_cmd_atten.sv
module vol_cmd_atten #(
  parameter int SMP_W = vca_pkg::SMP_W,
  parameter int CMD_W = vca_pkg::CMD_W,
  parameter int KEY_W = vca_pkg::KEY_W,
  parameter logic [KEY_W-1:0] KEY = vca_pkg::CMD_KEY,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_data,
  input  logic             host_clk,
  input  logic             host_load,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_left,
  output logic [SMP_W-1:0] out_right
);

  localparam int CODE_W = CMD_W - KEY_W;
  localparam int GAIN_W = vca_pkg::GAIN_W;
  localparam int NCH = 2;

  logic [2:0]        host_s;
  logic [CODE_W-1:0] level;
  logic [GAIN_W-1:0] gain_w, s1_gain_q;
  logic              s1_valid_q, out_valid_q;
  logic signed [SMP_W-1:0] in_smp [NCH];
  logic signed [SMP_W-1:0] s1_smp_q [NCH];
  logic signed [SMP_W-1:0] y_ch [NCH];

  // idle levels: load high, clock high, data low
  vca_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({host_load, host_clk, host_data}),
    .dout(host_s)
  );

  vca_cmd_rx #(.CMD_W(CMD_W), .KEY_W(KEY_W), .KEY(KEY)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sdat(host_s[0]), .sclk(host_s[1]), .sload(host_s[2]),
    .level(level)
  );

  vca_gain_rom #(.CODE_W(CODE_W), .GAIN_W(GAIN_W)) u_rom (
    .code(level), .gain(gain_w)
  );

  assign in_smp[0] = smp_left;
  assign in_smp[1] = smp_right;

  // stage 1: pair and gain captured together at the pair boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q  <= 1'b0;
      s1_gain_q   <= '0;
      out_valid_q <= 1'b0;
    end else begin
      s1_valid_q  <= smp_valid;
      out_valid_q <= s1_valid_q;
      if (smp_valid) s1_gain_q <= gain_w;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         s1_smp_q[c] <= '0;
      else if (smp_valid) s1_smp_q[c] <= in_smp[c];
    end
    vca_scale #(.SMP_W(SMP_W), .GAIN_W(GAIN_W), .FRAC(vca_pkg::GAIN_FRAC)) u_scale (
      .clk(clk), .rst_n(rst_n), .en(s1_valid_q),
      .smp(s1_smp_q[c]), .gain(s1_gain_q), .y(y_ch[c])
    );
  end

  assign out_valid = out_valid_q;
  assign out_left  = y_ch[0];
  assign out_right = y_ch[1];

  // R8: two-cycle latency
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> ##1 out_valid);
  // R6: zero gain yields silence on both channels
  a_r6_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid_q && s1_gain_q == '0) |=> (out_left == '0 && out_right == '0));
  // R4: no output without a preceding pair
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid_q |=> !out_valid);

endmodule

// File: tb/tb_vol_cmd_atten.sv
module tb_vol_cmd_atten;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_data = 1'b0, host_clk = 1'b1, host_load = 1'b1;
  logic smp_valid = 1'b0;
  logic [15:0] smp_left = '0, smp_right = '0;
  logic out_valid;
  logic [15:0] out_left, out_right;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] q_l[$], q_r[$];
  int q_c[$];
  string q_t[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vol_cmd_atten dut (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_clk(host_clk),
    .host_load(host_load), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_scale(input int s, input int g);
    longint p;
    p = (longint'(s) * g + 16384) >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return 16'(p);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [13:0] bits);
    for (int i = 0; i < 14; i++) begin
      host_data = bits[i];
      wait_clk(3); host_clk = 1'b0;
      wait_clk(3); host_clk = 1'b1;
      wait_clk(3);
    end
    host_data = 1'b0;
  endtask

  task automatic pulse_load();
    wait_clk(4); host_load = 1'b0;
    wait_clk(40); host_load = 1'b1;
    wait_clk(10);
  endtask

  task automatic send_cmd(input logic [7:0] key, input logic [5:0] code);
    shift_bits({code, key});
    pulse_load();
  endtask

  task automatic send_pair(input int l, input int r, input int g, input string tag);
    @(negedge clk);
    smp_valid = 1'b1; smp_left = 16'(l); smp_right = 16'(r);
    q_l.push_back(ref_scale(l, g));
    q_r.push_back(ref_scale(r, g));
    q_c.push_back(cyc + 2);
    q_t.push_back(tag);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_l.size() == 0) begin
        check("R8 unexpected out_valid", 1, 0);
      end else begin
        automatic string t = q_t.pop_front();
        check({t, " left"},  int'($signed(out_left)),  int'($signed(q_l.pop_front())));
        check({t, " right"}, int'($signed(out_right)), int'($signed(q_r.pop_front())));
        check("R8 latency cycle", cyc, q_c.pop_front());
      end
    end
  end

  initial begin
    fork
      begin
        // R4: nothing leaves the block while reset is held
        smp_valid = 1'b1; smp_left = 16'd1234; smp_right = 16'd999;
        wait_clk(4);
        check("R4 out_valid in reset", int'(out_valid), 0);
        check("R4 out_left in reset", int'(out_left), 0);
        check("R4 out_right in reset", int'(out_right), 0);
        smp_valid = 1'b0;
        wait_clk(1); rst_n = 1'b1; wait_clk(4);
        check("R4 out_valid after reset", int'(out_valid), 0);

        // R4/R5: level 0 after reset is unity gain
        send_pair(32767, -32768, 32768, "R4 code0 unity");
        send_pair(-1, 12345, 32768, "R5 code0");

        // R1/R2/R5 anchors
        send_cmd(8'h5D, 6'd1); wait_clk(5);
        send_pair(32767, -32768, 31729, "R5 code1");
        send_pair(-3, 1001, 31729, "R7 code1 small");
        send_cmd(8'h5D, 6'd31); wait_clk(5);
        send_pair(32767, -32768, 16385, "R5 code31");
        send_pair(1, -1, 16385, "R7 round near zero");
        send_pair(2, -3, 16385, "R7 round half");
        send_cmd(8'h5D, 6'd32); wait_clk(5);
        send_pair(32767, -32768, 15865, "R5 code32");
        send_pair(-20000, 7, 15865, "R9 distinct channels");

        // R3: keys off by one bit are rejected, level 32 stays
        send_cmd(8'h5C, 6'd0); wait_clk(5);
        send_pair(32767, -12345, 15865, "R3 key 5C");
        send_cmd(8'hDD, 6'd63); wait_clk(5);
        send_pair(32767, -12345, 15865, "R3 key DD");
        // R1: bit-reversed order gives a key that must be rejected
        send_cmd(8'hBA, 6'd0); wait_clk(5);
        send_pair(100, -100, 15865, "R1 order");

        send_cmd(8'h5D, 6'd62); wait_clk(5);
        send_pair(32767, -32768, 512, "R5 code62");
        send_pair(63, -64, 512, "R7 code62 small");

        // R6: mute
        send_cmd(8'h5D, 6'd63); wait_clk(5);
        send_pair(32767, -32768, 0, "R6 mute");
        send_pair(-1, 1, 0, "R6 mute small");

        // R10: shifting during load-low is ignored
        send_cmd(8'h5D, 6'd31); wait_clk(5);
        host_load = 1'b0; wait_clk(10);
        shift_bits({6'd1, 8'h5D});
        host_load = 1'b1; wait_clk(10);
        pulse_load(); wait_clk(5);
        send_pair(32767, -32768, 16385, "R10 load-low shift ignored");

        // R9: level switches between two consecutive pairs
        send_pair(20000, -20000, 16385, "R9 before change");
        send_cmd(8'h5D, 6'd0); wait_clk(2);
        send_pair(20000, -20000, 32768, "R9 after change");

        wait_clk(10);
        check("R8 queue drained", q_l.size(), 0);
      end
      begin
        wait_clk(150000);
        check("watchdog expired", 1, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule